// File: doc/BRIEF.md
# Wiper register and non-volatile word controller

This block carries out already-decoded commands against two 10-bit wiper registers and a 16-slot array of 16-bit non-volatile words. The array is modelled as plain registers. Slots 0 and 1 hold the saved settings for wiper 0 and wiper 1. Slots 2 to 14 are free for general storage. Slot 15 is reserved: commands cannot write it, and reading it returns a fixed constant.

Each command arrives as an opcode, an address and a data word, qualified by a one-cycle valid strobe. Read commands load a readback word, which a serial output stage can shift out during the next frame.

An active-low write-protect input freezes every register change except restores, which copy a wiper from its saved slot. An active-low preset input also restores both wipers on its falling edge. Any write to the array starts a busy window of programmable length. During that window, commands that touch the array are dropped.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after internal reset release, both wipers equal RESET_WIPER, the readback word is 0 and busy is low.
- R2: Opcode 11 writes data[9:0] into the wiper selected by addr[0] (0 = wiper 0, 1 = wiper 1). The wiper output shows the new value after the next rising clock edge.
- R3: Opcode 3 writes data into array slot addr when addr is 0 to 14. Opcode 2 saves the wiper selected by addr[0], zero-extended, into slot addr[0]. Slot 15 never changes.
- R4: Opcode 9 loads the readback word with the contents of slot addr. For addr 15 it loads RSVD_WORD instead.
- R5: Opcode 10 loads the readback word with the wiper selected by addr[0], zero-extended to 16 bits.
- R6: Opcode 1 loads the wiper selected by addr[0] from bits [9:0] of slot addr[0]. Opcode 8 loads both wipers from slots 0 and 1.
- R7: A falling edge of pr_n, seen as high in one cycle and low in the next, restores both wipers from slots 0 and 1. This happens whatever busy and wp_n are. A command presented in that same cycle is dropped.
- R8: While wp_n is low, opcodes 2, 3 and 11 change nothing and start no busy window. Restores and reads still act.
- R9: An accepted array write (opcode 2, or opcode 3 to a slot other than 15) raises busy at the next edge. Busy then stays high for exactly PROG_CYCLES cycles.
- R10: While busy is high, opcodes 1, 2, 3, 8 and 9 are dropped with no effect. Opcodes 10 and 11 still act.
- R11: Opcode 0, and any opcode not listed above, has no effect on any register. The same holds for any cycle with cmd_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Qualifies cmd, addr and data for one cycle |
| cmd | input | 4 | Opcode |
| addr | input | 4 | Slot address; bit 0 selects the wiper |
| data | input | 16 | Write data |
| wp_n | input | 1 | Active-low write protect |
| pr_n | input | 1 | Active-low preset; its falling edge restores both wipers |
| wiper0 | output | 10 | Wiper 0 setting |
| wiper1 | output | 10 | Wiper 1 setting |
| rdbk | output | 16 | Readback word |
| busy | output | 1 | Array write in progress |

## Verification
The bench builds the block with PROG_CYCLES set to 4 and RSVD_WORD set to 16'hA5C3.

The short busy window lets random traffic hit many cases within a few thousand cycles:
- commands landing inside and just after a programming window;
- write protect overlapping busy;
- preset pulses falling on top of pending commands.

The distinctive reserved constant separates a reserved-slot read from any stored word or zero value.

// File: rtl/wnc_pkg.sv
package wnc_pkg;
  typedef enum logic [3:0] {
    OP_NOP         = 4'd0,
    OP_RESTORE_ONE = 4'd1,
    OP_STORE_WIPER = 4'd2,
    OP_WRITE_NV    = 4'd3,
    OP_RESTORE_ALL = 4'd8,
    OP_READ_NV     = 4'd9,
    OP_READ_WIPER  = 4'd10,
    OP_WRITE_WIPER = 4'd11
  } op_e;
endpackage

// File: rtl/wnc_decode.sv
module wnc_decode
  import wnc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              pr_fall,
  output logic              wr_wiper,
  output logic              nv_we,
  output logic              nv_from_wiper,
  output logic              rs_one,
  output logic              rs_all,
  output logic              rd_nv,
  output logic              rd_wiper
);
  localparam logic [ADDR_W-1:0] RSVD_ADDR = {ADDR_W{1'b1}};

  op_e  op;
  logic go;
  logic nv_op;
  logic prot;

  always_comb begin
    op    = op_e'(cmd);
    prot  = ~wp_n;
    nv_op = 1'b0;
    case (op)
      OP_RESTORE_ONE, OP_STORE_WIPER, OP_WRITE_NV,
      OP_RESTORE_ALL, OP_READ_NV: nv_op = 1'b1;
      default:                    nv_op = 1'b0;
    endcase
    go            = valid & ~pr_fall & ~(busy & nv_op);
    wr_wiper      = go & ~prot & (op == OP_WRITE_WIPER);
    nv_from_wiper = (op == OP_STORE_WIPER);
    nv_we         = go & ~prot &
                    ((op == OP_STORE_WIPER) |
                     ((op == OP_WRITE_NV) & (addr != RSVD_ADDR)));
    rs_one        = go & (op == OP_RESTORE_ONE);
    rs_all        = pr_fall | (go & (op == OP_RESTORE_ALL));
    rd_nv         = go & (op == OP_READ_NV);
    rd_wiper      = go & (op == OP_READ_WIPER);
  end

  // R10
  busy_drops_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && valid && (cmd == 4'd3 || cmd == 4'd2)) |-> !nv_we);
endmodule

// File: rtl/wnc_wiper.sv
module wnc_wiper #(
  parameter int               WIPER_W     = 10,
  parameter logic [WIPER_W-1:0] RESET_WIPER = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n,
  input  logic               wr_en,
  input  logic [WIPER_W-1:0] wr_val,
  input  logic               rs_en,
  input  logic [WIPER_W-1:0] rs_val,
  output logic [WIPER_W-1:0] q
);
  logic [WIPER_W-1:0] q_d;
  logic               q_en;

  always_comb begin
    q_en = rs_en | wr_en;
    q_d  = rs_en ? rs_val : wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_WIPER;
    else if (q_en) q <= q_d;
  end

  // R8
  wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !rs_en) |=> $stable(q));
endmodule

// File: rtl/wnc_nvm.sv
module wnc_nvm #(
  parameter int              WORD_W      = 16,
  parameter int              ADDR_W      = 4,
  parameter int              PROG_CYCLES = 2000,
  parameter logic [WORD_W-1:0] RSVD_WORD   = '0,
  parameter logic [WORD_W-1:0] SLOT_INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] slot0,
  output logic [WORD_W-1:0] slot1,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] RSVD_ADDR = {ADDR_W{1'b1}};

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic slot_en;
      assign slot_en = we & (waddr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem[gi] <= (gi < 2) ? SLOT_INIT : '0;
        else if (slot_en) mem[gi] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    if (we)              cnt_d = CNT_W'(PROG_CYCLES);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy  = (cnt_q != '0);
  assign rdata = (raddr == RSVD_ADDR) ? RSVD_WORD : mem[raddr];
  assign slot0 = mem[0];
  assign slot1 = mem[1];

  // R3
  rsvd_slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mem[DEPTH-1]));
  // R9
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> busy);
endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
  import wnc_pkg::*;
#(
  parameter int               WIPER_W     = 10,
  parameter int               WORD_W      = 16,
  parameter int               ADDR_W      = 4,
  parameter int               PROG_CYCLES = 2000,
  parameter logic [WORD_W-1:0]  RSVD_WORD   = 16'hFFFF,
  parameter logic [WIPER_W-1:0] RESET_WIPER = 10'h200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  data,
  input  logic               wp_n,
  input  logic               pr_n,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic [WORD_W-1:0]  rdbk,
  output logic               busy
);
  localparam int NWIPER = 2;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       pr_q;
  logic       pr_fall;
  logic       wr_wiper, nv_we, nv_from_wiper, rs_one, rs_all, rd_nv, rd_wiper;
  logic [WORD_W-1:0]  nv_rdata, slot0, slot1, nv_wdata;
  logic [ADDR_W-1:0]  nv_waddr;
  logic [WIPER_W-1:0] wq [NWIPER];
  logic [WIPER_W-1:0] sel_wiper;
  logic [WORD_W-1:0]  rdbk_d;
  logic               rdbk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pr_q <= 1'b1;
    else            pr_q <= pr_n;
  end
  assign pr_fall = pr_q & ~pr_n;

  wnc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .valid(cmd_valid), .cmd(cmd), .addr(addr),
    .wp_n(wp_n), .busy(busy), .pr_fall(pr_fall),
    .wr_wiper(wr_wiper), .nv_we(nv_we), .nv_from_wiper(nv_from_wiper),
    .rs_one(rs_one), .rs_all(rs_all), .rd_nv(rd_nv), .rd_wiper(rd_wiper));

  assign sel_wiper = wq[addr[0]];
  assign nv_waddr  = nv_from_wiper ? ADDR_W'(addr[0]) : addr;
  assign nv_wdata  = nv_from_wiper ? WORD_W'(sel_wiper) : data;

  wnc_nvm #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
    .RSVD_WORD(RSVD_WORD), .SLOT_INIT(WORD_W'(RESET_WIPER))
  ) u_nvm (
    .clk(clk), .rst_n(rst_int_n), .we(nv_we), .waddr(nv_waddr),
    .wdata(nv_wdata), .raddr(addr), .rdata(nv_rdata),
    .slot0(slot0), .slot1(slot1), .busy(busy));

  genvar gw;
  generate
    for (gw = 0; gw < NWIPER; gw++) begin : g_wiper
      logic               w_wr, w_rs;
      logic [WIPER_W-1:0] w_rs_val;
      assign w_wr     = wr_wiper & (addr[0] == gw[0]);
      assign w_rs     = rs_all | (rs_one & (addr[0] == gw[0]));
      assign w_rs_val = (gw == 0) ? slot0[WIPER_W-1:0] : slot1[WIPER_W-1:0];
      wnc_wiper #(.WIPER_W(WIPER_W), .RESET_WIPER(RESET_WIPER)) u_w (
        .clk(clk), .rst_n(rst_int_n), .wp_n(wp_n),
        .wr_en(w_wr), .wr_val(data[WIPER_W-1:0]),
        .rs_en(w_rs), .rs_val(w_rs_val), .q(wq[gw]));
    end
  endgenerate

  assign wiper0 = wq[0];
  assign wiper1 = wq[1];

  always_comb begin
    rdbk_en = rd_nv | rd_wiper;
    rdbk_d  = rd_nv ? nv_rdata : WORD_W'(sel_wiper);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   rdbk <= '0;
    else if (rdbk_en) rdbk <= rdbk_d;
  end

  // R7
  preset_restore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pr_fall |=> (wiper0 == $past(slot0[WIPER_W-1:0]) &&
                 wiper1 == $past(slot1[WIPER_W-1:0])));
  // R4
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_nv && addr == {ADDR_W{1'b1}}) |=> (rdbk == RSVD_WORD));
endmodule

// File: tb/wiper_nv_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_nv_ctrl_tb_top;
  localparam int          PROG = 4;
  localparam logic [15:0] RSVD = 16'hA5C3;
  localparam logic [9:0]  RSTW = 10'h200;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [3:0] cmd, addr;
  logic [15:0] data;
  logic wp_n, pr_n;
  logic [9:0] wiper0, wiper1;
  logic [15:0] rdbk;
  logic busy;

  int checks = 0;
  int failures = 0;

  logic [9:0]  ew [2];
  logic [15:0] env [16];
  logic [15:0] erd;
  int          ecnt;
  logic        epr;

  always #2.5 clk = ~clk;

  wiper_nv_ctrl #(.PROG_CYCLES(PROG), .RSVD_WORD(RSVD), .RESET_WIPER(RSTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr),
    .data(data), .wp_n(wp_n), .pr_n(pr_n), .wiper0(wiper0), .wiper1(wiper1),
    .rdbk(rdbk), .busy(busy));

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "wiper0", 16'(wiper0), 16'(ew[0]));
    chk(tag, "wiper1", 16'(wiper1), 16'(ew[1]));
    chk(tag, "rdbk", rdbk, erd);
    chk("R9", "busy", 16'(busy), 16'(ecnt != 0));
  endtask

  function automatic bit is_nv_op(input logic [3:0] c);
    return c == 4'd1 || c == 4'd2 || c == 4'd3 || c == 4'd8 || c == 4'd9;
  endfunction

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [3:0] c, input logic [3:0] a,
                      input logic [15:0] d, input logic wp, input logic pr);
    string tag;
    bit    fall, go, prot, nvw;
    logic [9:0] sw;
    cmd_valid = v; cmd = c; addr = a; data = d; wp_n = wp; pr_n = pr;
    @(posedge clk);
    fall = epr && !pr;
    prot = !wp;
    go   = v && !fall && !((ecnt != 0) && is_nv_op(c));
    nvw  = 0;
    sw   = ew[a[0]];
    if (fall)                                  tag = "R7";
    else if (v && (ecnt != 0) && is_nv_op(c))  tag = "R10";
    else if (v && prot && (c == 2 || c == 3 || c == 11)) tag = "R8";
    else if (!v)                               tag = "R11";
    else case (c)
      4'd11:      tag = "R2";
      4'd2, 4'd3: tag = "R3";
      4'd9:       tag = "R4";
      4'd10:      tag = "R5";
      4'd1, 4'd8: tag = "R6";
      default:    tag = "R11";
    endcase
    if (fall) begin
      ew[0] = env[0][9:0];
      ew[1] = env[1][9:0];
    end
    if (go) begin
      case (c)
        4'd1:  ew[a[0]] = env[a[0]][9:0];
        4'd8:  begin ew[0] = env[0][9:0]; ew[1] = env[1][9:0]; end
        4'd9:  erd = (a == 4'hF) ? RSVD : env[a];
        4'd10: erd = 16'(sw);
        4'd11: if (!prot) ew[a[0]] = d[9:0];
        4'd3:  if (!prot && a != 4'hF) begin env[a] = d; nvw = 1; end
        4'd2:  if (!prot) begin env[a[0]] = 16'(sw); nvw = 1; end
        default: ;
      endcase
    end
    if (nvw)            ecnt = PROG;
    else if (ecnt != 0) ecnt--;
    epr = pr;
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 1);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int busy_len;
    void'($urandom(32'd7321));
    rst_n = 0; cmd_valid = 0; cmd = 0; addr = 0; data = 0; wp_n = 1; pr_n = 1;
    ew[0] = RSTW; ew[1] = RSTW;
    for (int i = 0; i < 16; i++) env[i] = (i < 2) ? 16'(RSTW) : 16'h0;
    erd = 0; ecnt = 0; epr = 1;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1", "wiper0 in reset", 16'(wiper0), 16'(RSTW));
    chk("R1", "rdbk in reset", rdbk, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // directed corner cases
    step(1, 11, 4'h0, 16'h0155, 1, 1);        // R2 write wiper 0
    step(1, 11, 4'h1, 16'hF3AA, 1, 1);        // R2 upper data bits dropped
    step(1, 10, 4'h1, 0, 1, 1);               // R5 read wiper 1
    chk("R5", "rdbk wiper1", rdbk, 16'h03AA);
    step(1, 3, 4'h7, 16'hBEEF, 1, 1);         // R3 write slot 7, R9 busy starts
    busy_len = 0;
    while (busy && busy_len < 20) begin
      busy_len++;
      step(1, 9, 4'h7, 0, 1, 1);              // R10 reads dropped while busy
    end
    chk("R9", "busy length", 16'(busy_len), 16'(PROG));
    step(1, 9, 4'h7, 0, 1, 1);                // R4 read slot 7
    chk("R4", "rdbk slot7", rdbk, 16'hBEEF);
    step(1, 3, 4'hF, 16'h1234, 1, 1);         // R3 reserved slot write rejected
    chk("R3", "no busy on reserved write", 16'(busy), 16'h0);
    step(1, 9, 4'hF, 0, 1, 1);                // R4 reserved constant
    chk("R4", "rdbk reserved", rdbk, RSVD);
    step(1, 2, 4'h0, 0, 1, 1);                // R3 save wiper 0 to slot 0
    idle(PROG);
    step(1, 11, 4'h0, 16'h0011, 0, 1);        // R8 blocked
    chk("R8", "wiper0 protected", 16'(wiper0), 16'h0155);
    step(1, 11, 4'h0, 16'h0022, 1, 1);
    step(1, 1, 4'h0, 0, 0, 1);                // R6 restore under protect
    chk("R6", "wiper0 restored", 16'(wiper0), 16'h0155);
    step(1, 11, 4'h1, 16'h0077, 1, 1);
    step(1, 11, 4'h1, 16'h0099, 1, 0);        // R7 preset fall drops command
    chk("R7", "wiper1 preset", 16'(wiper1), 16'(RSTW));
    step(1, 0, 4'h3, 16'hFFFF, 1, 1);         // R11 NOP
    step(1, 4'd5, 4'h2, 16'hFFFF, 1, 1);      // R11 undefined opcode
    step(1, 8, 4'h0, 0, 0, 1);                // R6 restore all under protect

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] c, a;
      int r;
      r = $urandom % 10;
      case (r)
        0: c = 0;  1: c = 1;  2: c = 2;  3: c = 3;  4: c = 8;
        5: c = 9;  6: c = 10; 7, 9: c = 11;
        default: c = 4'($urandom);
      endcase
      a = (($urandom % 6) == 0) ? 4'hF : 4'($urandom);
      step(($urandom % 5) != 0, c, a, 16'($urandom), ($urandom % 4) != 0,
           ($urandom % 40) != 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule